// File: doc/BRIEF.md
# Ethernet PHY LED Mode Controller

This block drives four indicator LEDs for a tri-speed Ethernet PHY: a link LED, a traffic LED, a 100 Mb/s LED and a 1000 Mb/s LED. A single 16-bit control register holds one 4-bit mode code per LED. The register is written and read back over a plain write-enable/data register port. Each clock, every LED's mode code is evaluated against the live link status: link state, speed, duplex, transmit and receive activity, and collision. The result is a steady on, steady off, or blinking output.

Single-cycle activity and collision events are stretched by a retriggerable down-counter, so even one short packet lights a LED for a visible time. All blinking uses one shared 50% square wave from a free-running prescaler, so every LED that blinks does so in step. The outputs are registered and active high.

Top module: `phy_led_ctrl`

## Requirements
- R1: The control register resets to 0x4A10. A write with `ctrl_wr_en` high replaces the whole register on that edge, and `ctrl_rd_data` shows the stored value from the next cycle. The link LED (`led_out[3]`) uses bits 15:12, the traffic LED (`led_out[2]`) uses bits 11:8, the 100 Mb/s LED (`led_out[1]`) uses bits 7:4 and the 1000 Mb/s LED (`led_out[0]`) uses bits 3:0.
- R2: `link_speed` encodes 0 = 10 Mb/s, 1 = 100 Mb/s, 2 = 1000 Mb/s and 3 = no valid speed. Mode 0x0 is lit while the link is up at 1000 Mb/s, mode 0x1 while it is up at 100 Mb/s, and mode 0x2 while it is up at 10 Mb/s.
- R3: Mode 0x3 is steadily lit at 1000 Mb/s, follows the blink wave at 100 Mb/s, and is dark at any other speed.
- R4: Mode 0x4 is lit while the link is up. Modes 0x5, 0x6 and 0x7 are lit while the link is up and, respectively, stretched transmit activity, stretched receive activity, or either one is present.
- R5: Mode 0x8 is lit while the link is up in full duplex. Mode 0x9 is lit while the link is up and a stretched collision is present.
- R6: With the link up, mode 0xA is on and follows the blink wave while any stretched activity is present, and mode 0xB does the same for receive activity only. Mode 0xC follows the blink wave while a stretched collision is present, and otherwise is lit when full duplex is set.
- R7: Mode 0xD follows the blink wave, mode 0xE is always on and mode 0xF is always off, whatever the link state.
- R8: While `link_up` is low, every LED whose mode is in the range 0x0 to 0xC is dark on the next cycle.
- R9: An event on `tx_activity`, `rx_activity` or `collision` makes the matching stretched condition true for the following STRETCH_CYCLES cycles. A new event during that window restarts the full window.
- R10: The blink wave is low after reset and toggles every BLINK_HALF cycles. All LEDs share this one wave.
- R11: `led_out` is registered: it reflects the register and inputs sampled at the previous edge. It is all zero during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr_en | input | 1 | Write strobe for the control register |
| ctrl_wr_data | input | 16 | Value to store |
| ctrl_rd_data | output | 16 | Current control register value |
| link_up | input | 1 | Link is established |
| link_speed | input | 2 | Link speed code (see R2) |
| full_duplex | input | 1 | Full duplex in effect |
| tx_activity | input | 1 | Transmit event pulse |
| rx_activity | input | 1 | Receive event pulse |
| collision | input | 1 | Collision event pulse |
| led_out | output | 4 | LED drives: [3] link, [2] traffic, [1] 100 Mb/s, [0] 1000 Mb/s |

## Verification
Every one of the sixteen mode codes is loaded into all four fields. The block is then run under sparse pseudo-random events, link flaps, speed changes and duplex toggles, and a behavioural model is compared with it on every cycle. This separates the speed, activity and combined modes from one another and checks that the on, off and blink choices come out right.

Directed runs cover the remaining cases. Back-to-back transmit pulses tell a restarting stretch window apart from one that does not restart. A link drop under the reset-default codes shows that the gating acts at once. A continuous-blink pattern pins down the period and phase of the shared wave, and a mixed write shows that each field steers only its own LED.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

  localparam int NUM_LEDS   = 4;
  localparam int MODE_W     = 4;
  localparam int CTRL_W     = NUM_LEDS * MODE_W;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h4A10;

  typedef enum logic [MODE_W-1:0] {
    MODE_ON_1000     = 4'h0,
    MODE_ON_100      = 4'h1,
    MODE_ON_10       = 4'h2,
    MODE_1000_BLK100 = 4'h3,
    MODE_LINK        = 4'h4,
    MODE_TX          = 4'h5,
    MODE_RX          = 4'h6,
    MODE_TXRX        = 4'h7,
    MODE_FDX         = 4'h8,
    MODE_COL         = 4'h9,
    MODE_LINK_ACT    = 4'hA,
    MODE_LINK_RXACT  = 4'hB,
    MODE_FDX_COL     = 4'hC,
    MODE_BLINK       = 4'hD,
    MODE_FORCE_ON    = 4'hE,
    MODE_FORCE_OFF   = 4'hF
  } led_mode_e;

  typedef enum logic [1:0] {
    SPD_10   = 2'd0,
    SPD_100  = 2'd1,
    SPD_1000 = 2'd2,
    SPD_NONE = 2'd3
  } speed_e;

  typedef struct packed {
    logic   link;
    speed_e speed;
    logic   fdx;
    logic   tx;
    logic   rx;
    logic   col;
    logic   blink;
  } led_status_t;

endpackage

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
  parameter int BLINK_HALF = 4096
) (
  input  logic clk,
  input  logic rst,
  output logic blink_o
);
  localparam int CW = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(BLINK_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign blink_o = phase_q;

  // R10: the wave only moves at the end of a half period
  assert_blink_step_R10: assert property (@(posedge clk) disable iff (rst)
    (phase_q != $past(phase_q)) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/led_event_stretch.sv
module led_event_stretch #(
  parameter int STRETCH_CYCLES = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic event_i,
  output logic active_o
);
  localparam int SW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [SW-1:0] LOAD = SW'(STRETCH_CYCLES);

  logic [SW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)               left_q <= '0;
    else if (event_i)      left_q <= LOAD;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign active_o = (left_q != '0);

  // R9: an event always opens (or reopens) the window
  assert_event_opens_R9: assert property (@(posedge clk) disable iff (rst)
    event_i |=> (active_o && left_q == LOAD));

endmodule

// File: rtl/led_mode_decode.sv
module led_mode_decode
  import phy_led_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  led_status_t       st_i,
  output logic              lit_o
);
  logic any_act;
  assign any_act = st_i.tx | st_i.rx;

  always_comb begin
    lit_o = 1'b0;
    case (led_mode_e'(mode_i))
      MODE_ON_1000:     lit_o = st_i.link && st_i.speed == SPD_1000;
      MODE_ON_100:      lit_o = st_i.link && st_i.speed == SPD_100;
      MODE_ON_10:       lit_o = st_i.link && st_i.speed == SPD_10;
      MODE_1000_BLK100: lit_o = st_i.link && (st_i.speed == SPD_1000 ||
                                (st_i.speed == SPD_100 && st_i.blink));
      MODE_LINK:        lit_o = st_i.link;
      MODE_TX:          lit_o = st_i.link && st_i.tx;
      MODE_RX:          lit_o = st_i.link && st_i.rx;
      MODE_TXRX:        lit_o = st_i.link && any_act;
      MODE_FDX:         lit_o = st_i.link && st_i.fdx;
      MODE_COL:         lit_o = st_i.link && st_i.col;
      MODE_LINK_ACT:    lit_o = st_i.link && (any_act ? st_i.blink : 1'b1);
      MODE_LINK_RXACT:  lit_o = st_i.link && (st_i.rx ? st_i.blink : 1'b1);
      MODE_FDX_COL:     lit_o = st_i.link && (st_i.col ? st_i.blink : st_i.fdx);
      MODE_BLINK:       lit_o = st_i.blink;
      MODE_FORCE_ON:    lit_o = 1'b1;
      MODE_FORCE_OFF:   lit_o = 1'b0;
      default:          lit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
  import phy_led_pkg::*;
#(
  parameter int BLINK_HALF     = 4096,
  parameter int STRETCH_CYCLES = 2048
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctrl_wr_en,
  input  logic [CTRL_W-1:0]   ctrl_wr_data,
  output logic [CTRL_W-1:0]   ctrl_rd_data,
  input  logic                link_up,
  input  logic [1:0]          link_speed,
  input  logic                full_duplex,
  input  logic                tx_activity,
  input  logic                rx_activity,
  input  logic                collision,
  output logic [NUM_LEDS-1:0] led_out
);
  localparam int NUM_EVT = 3;

  logic [CTRL_W-1:0]   ctrl_q;
  logic [NUM_LEDS-1:0] lit;
  logic [NUM_LEDS-1:0] led_q;
  logic [NUM_EVT-1:0]  evt_raw;
  logic [NUM_EVT-1:0]  evt_held;
  logic                blink;
  led_status_t         status;

  always_ff @(posedge clk) begin
    if (rst)             ctrl_q <= CTRL_RESET;
    else if (ctrl_wr_en) ctrl_q <= ctrl_wr_data;
  end
  assign ctrl_rd_data = ctrl_q;

  led_blink_gen #(.BLINK_HALF(BLINK_HALF)) u_blink (
    .clk(clk), .rst(rst), .blink_o(blink)
  );

  assign evt_raw = {collision, rx_activity, tx_activity};

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_stretch
    led_event_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_str (
      .clk(clk), .rst(rst), .event_i(evt_raw[e]), .active_o(evt_held[e])
    );
  end

  assign status = '{link:  link_up,
                    speed: speed_e'(link_speed),
                    fdx:   full_duplex,
                    tx:    evt_held[0],
                    rx:    evt_held[1],
                    col:   evt_held[2],
                    blink: blink};

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    led_mode_decode u_dec (
      .mode_i(ctrl_q[i*MODE_W +: MODE_W]),
      .st_i  (status),
      .lit_o (lit[i])
    );

    // R8: link-qualified modes go dark as soon as the link is lost
    assert_link_down_dark_R8: assert property (@(posedge clk) disable iff (rst)
      (!link_up && ctrl_q[i*MODE_W +: MODE_W] <= 4'hC) |=> !led_out[i]);
    // R7: forced codes ignore every status input
    assert_force_on_R7: assert property (@(posedge clk) disable iff (rst)
      (ctrl_q[i*MODE_W +: MODE_W] == 4'hE) |=> led_out[i]);
    assert_force_off_R7: assert property (@(posedge clk) disable iff (rst)
      (ctrl_q[i*MODE_W +: MODE_W] == 4'hF) |=> !led_out[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) led_q <= '0;
    else     led_q <= lit;
  end
  assign led_out = led_q;

  // R1: a write is visible on the read port one cycle later
  assert_readback_R1: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr_en |=> (ctrl_rd_data == $past(ctrl_wr_data)));
  // R11: reset leaves outputs dark and the register at its default
  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (led_out == '0 && ctrl_rd_data == CTRL_RESET));

endmodule

// File: tb/phy_led_ctrl_bench.sv
module phy_led_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BH = 5;
  localparam int ST = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_wr_en = 1'b0;
  logic [15:0] ctrl_wr_data = '0;
  logic [15:0] ctrl_rd_data;
  logic        link_up = 1'b0;
  logic [1:0]  link_speed = 2'd2;
  logic        full_duplex = 1'b0;
  logic        tx_activity = 1'b0;
  logic        rx_activity = 1'b0;
  logic        collision = 1'b0;
  logic [3:0]  led_out;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    model_ok = 1'b0;
  string tag = "R11";
  int unsigned seed = 32'h1234_5678;

  // behavioural reference state
  logic [15:0] m_ctrl;
  logic [3:0]  exp_led;
  int          m_pre, m_tx, m_rx, m_col;
  bit          m_phase;

  phy_led_ctrl #(.BLINK_HALF(BH), .STRETCH_CYCLES(ST)) u_phy_led_ctrl (
    .clk(clk), .rst(rst), .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
    .ctrl_rd_data(ctrl_rd_data), .link_up(link_up), .link_speed(link_speed),
    .full_duplex(full_duplex), .tx_activity(tx_activity),
    .rx_activity(rx_activity), .collision(collision), .led_out(led_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit want(input int code, input bit lk, input int spd,
                              input bit fdx, input bit tx, input bit rx,
                              input bit col, input bit bl);
    case (code)
      0:  return lk && spd == 2;
      1:  return lk && spd == 1;
      2:  return lk && spd == 0;
      3:  return lk && (spd == 2 || (spd == 1 && bl));
      4:  return lk;
      5:  return lk && tx;
      6:  return lk && rx;
      7:  return lk && (tx || rx);
      8:  return lk && fdx;
      9:  return lk && col;
      10: return lk && ((tx || rx) ? bl : 1'b1);
      11: return lk && (rx ? bl : 1'b1);
      12: return lk && (col ? bl : fdx);
      13: return bl;
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input int code);
    if (code <= 2)  return "R2";
    if (code == 3)  return "R3";
    if (code <= 7)  return "R4";
    if (code <= 9)  return "R5";
    if (code <= 12) return "R6";
    return "R7";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 16'h4A10; exp_led = '0;
      m_pre = 0; m_phase = 1'b0; m_tx = 0; m_rx = 0; m_col = 0;
    end else begin
      for (int i = 0; i < 4; i++)
        exp_led[i] = want(int'(m_ctrl[i*4 +: 4]), link_up, int'(link_speed),
                          full_duplex, m_tx > 0, m_rx > 0, m_col > 0, m_phase);
      m_tx  = tx_activity ? ST : (m_tx  > 0 ? m_tx  - 1 : 0);
      m_rx  = rx_activity ? ST : (m_rx  > 0 ? m_rx  - 1 : 0);
      m_col = collision   ? ST : (m_col > 0 ? m_col - 1 : 0);
      if (m_pre == BH - 1) begin m_pre = 0; m_phase = ~m_phase; end
      else m_pre = m_pre + 1;
      if (ctrl_wr_en) m_ctrl = ctrl_wr_data;
    end
    model_ok = 1'b1;
  end

  always @(negedge clk) begin
    if (model_ok && !done) begin
      checks++;
      if (led_out !== exp_led) begin
        errors++;
        $display("FAIL %s led_out actual %b expected %b", tag, led_out, exp_led);
      end
      checks++;
      if (ctrl_rd_data !== m_ctrl) begin
        errors++;
        $display("FAIL R1 ctrl_rd_data actual %h expected %h", ctrl_rd_data, m_ctrl);
      end
    end
  end

  task automatic write_ctrl(input logic [15:0] v);
    @(negedge clk); ctrl_wr_en = 1'b1; ctrl_wr_data = v;
    @(negedge clk); ctrl_wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      tx_activity = 1'b0; rx_activity = 1'b0; collision = 1'b0;
    end
  endtask

  task automatic wander(input int n);
    repeat (n) begin
      @(negedge clk);
      seed = seed * 32'd1103515245 + 32'd12345;
      tx_activity = (seed[10:7]  == 4'd0);
      rx_activity = (seed[14:11] == 4'd0);
      collision   = (seed[18:15] == 4'd0);
      if (seed[23:19] == 5'd0) link_up = ~link_up;
      if (seed[26:24] == 3'd0) link_speed = seed[28:27];
      if (seed[31:29] == 3'd0) full_duplex = ~full_duplex;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 / R1: reset state seen at the ports
    checks++;
    if (led_out !== 4'b0000 || ctrl_rd_data !== 16'h4A10) begin
      errors++;
      $display("FAIL R11 reset led %b rd %h expected 0000 4a10", led_out, ctrl_rd_data);
    end

    link_up = 1'b1;
    for (int c = 0; c < 16; c++) begin
      logic [3:0] cv;
      cv = c[3:0];
      tag = req_of(c);
      write_ctrl({cv, cv, cv, cv});
      wander(90);
    end

    // R1: each field steers only its own LED
    tag = "R1";
    write_ctrl(16'hE0F4);
    link_up = 1'b1; link_speed = 2'd2;
    wander(60);

    // R9: retriggered stretch window
    tag = "R9";
    link_up = 1'b1;
    write_ctrl(16'h5555);
    idle(12);
    @(negedge clk); tx_activity = 1'b1;
    idle(4);
    @(negedge clk); tx_activity = 1'b1;
    idle(14);

    // R8: link loss under the default codes
    tag = "R8";
    write_ctrl(16'h4A10);
    link_up = 1'b1; link_speed = 2'd1; full_duplex = 1'b1;
    wander(20);
    link_up = 1'b0;
    repeat (20) begin
      @(negedge clk); tx_activity = 1'b1; rx_activity = 1'b1;
    end
    idle(2);

    // R10: shared blink wave period
    tag = "R10";
    write_ctrl(16'hDDDD);
    idle(4 * BH + 3);

    // R11: reset in mid-run clears outputs
    tag = "R11";
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    idle(10);

    finish_run();
  end

endmodule